// File: doc/BRIEF.md
# Register/Immediate Integer Execute Stage with Opcode Decode

This block is the integer execute step for a small fixed-width instruction set. It takes a 32-bit instruction word and the two source register values read for it, and finds the operation from the 6-bit primary opcode and, for register-register instructions, the 6-bit function field. It computes a 32-bit result. The second operand is either the second register value or the 16-bit immediate field. The immediate is sign-extended or zero-extended depending on the opcode. One registered output stage gives the result with a write strobe and the destination register index, ready for the register file's write port.

Seven operations are supported: register add, subtract and signed set-less-than; immediate add and immediate signed set-less-than; immediate OR; and the upper-immediate load. The upper-immediate load followed by an immediate OR into the same register builds any 32-bit constant. Any other encoding produces no write. Writes aimed at register 0 are dropped, because that register is hard-wired to zero.

Top module: `rfi_alu`

## Requirements
- R1: Opcode 0 (instr[31:26]) with function 32 (instr[5:0]) writes src_a + src_b, modulo 2^32, to the register in instr[15:11].
- R2: Opcode 0 with function 34 writes src_a - src_b, modulo 2^32, to the register in instr[15:11].
- R3: Opcode 0 with function 42 writes 1 when src_a is less than src_b as signed two's complement values, and 0 otherwise, to the register in instr[15:11].
- R4: Opcode 8 writes src_a plus the sign-extended instr[15:0] to the register in instr[20:16].
- R5: Opcode 10 writes 1 when src_a is signed-less-than the sign-extended instr[15:0], and 0 otherwise, to instr[20:16].
- R6: Opcode 13 writes src_a OR the zero-extended instr[15:0] to instr[20:16].
- R7: Opcode 15 writes instr[15:0] into bits 31:16 with bits 15:0 cleared, to instr[20:16]. That result used as src_a of an opcode-13 instruction yields the full 32-bit constant.
- R8: A supported instruction whose destination index is 0 gives out_valid=1 and out_we=0.
- R9: An unsupported opcode, or opcode 0 with any other function value, gives out_valid=1, out_we=0, out_dst=0 and out_data=0.
- R10: While rst is high at a clock edge, all outputs are 0 after that edge.
- R11: Outputs appear exactly one clock after the instruction is sampled with in_valid=1. With in_valid=0, out_valid and out_we are 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| out_valid | output | 1 | A result for a sampled instruction is present |
| out_we | output | 1 | Register file write enable |
| out_dst | output | 5 | Destination register index |
| out_data | output | 32 | Result value |

## Verification
The assertions assume that rst is high at the first clock edge and that the instruction fields are known whenever in_valid is high. The upper-immediate and set-less-than checks look at the opcode and function that were sampled one cycle earlier. The stimulus holds reset for several cycles before any instruction. It changes inputs only on the falling clock edge and builds every instruction word from explicit field values. Both supported and unsupported encodings, destination 0, and idle cycles are mixed in.

// File: rtl/rfi_alu_pkg.sv
package rfi_alu_pkg;

  // field positions of the instruction word (decoded by the fetch side too)
  localparam int OP_LSB = 26;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;
  localparam int IMM_W  = 16;

  // primary opcodes
  localparam logic [OP_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OP_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OP_W-1:0] OPC_SLTI = 6'd10;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'd13;
  localparam logic [OP_W-1:0] OPC_LUI  = 6'd15;

  // function codes for opcode 0
  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    K_NONE,
    K_ADD,
    K_SUB,
    K_SLT,
    K_OR,
    K_LUI
  } alu_kind_e;

  typedef struct packed {
    alu_kind_e kind;
    logic      use_imm;
    logic      zext;
    logic      wr_rd;
    logic      legal;
  } dec_t;

endpackage

// File: rtl/rfi_decode.sv
module rfi_decode
  import rfi_alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic [XLEN-1:0] instr,
  output dec_t            dec,
  output logic [RIDX-1:0] dst
);

  logic [OP_W-1:0] opc;
  logic [FN_W-1:0] fnc;
  logic [RIDX-1:0] rt_f;
  logic [RIDX-1:0] rd_f;
  logic            unused_fields;

  assign opc  = instr[OP_LSB +: OP_W];
  assign fnc  = instr[FN_W-1:0];
  assign rt_f = instr[RT_LSB +: RIDX];
  assign rd_f = instr[RD_LSB +: RIDX];

  // first-source index and shift amount are read elsewhere
  assign unused_fields = ^{instr[OP_LSB-1:RT_LSB+RIDX], instr[RD_LSB-1:FN_W]};

  always_comb begin
    dec = '{kind: K_NONE, use_imm: 1'b0, zext: 1'b0, wr_rd: 1'b0, legal: 1'b0};
    unique case (opc)
      OPC_REG: begin
        dec.wr_rd = 1'b1;
        unique case (fnc)
          FN_ADD:  begin dec.kind = K_ADD; dec.legal = 1'b1; end
          FN_SUB:  begin dec.kind = K_SUB; dec.legal = 1'b1; end
          FN_SLT:  begin dec.kind = K_SLT; dec.legal = 1'b1; end
          default: dec.legal = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        dec.kind = K_ADD; dec.use_imm = 1'b1; dec.legal = 1'b1;
      end
      OPC_SLTI: begin
        dec.kind = K_SLT; dec.use_imm = 1'b1; dec.legal = 1'b1;
      end
      OPC_ORI: begin
        dec.kind = K_OR; dec.use_imm = 1'b1; dec.zext = 1'b1; dec.legal = 1'b1;
      end
      OPC_LUI: begin
        dec.kind = K_LUI; dec.use_imm = 1'b1; dec.zext = 1'b1; dec.legal = 1'b1;
      end
      default: dec.legal = 1'b0;
    endcase
  end

  assign dst = dec.wr_rd ? rd_f : rt_f;

endmodule

// File: rtl/rfi_immext.sv
module rfi_immext #(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic [IMMW-1:0] imm,
  input  logic            zext,
  output logic [XLEN-1:0] ext
);

  localparam int PADW = XLEN - IMMW;

  generate
    if (PADW > 0) begin : g_pad
      logic fill;
      assign fill = zext ? 1'b0 : imm[IMMW-1];
      assign ext  = {{PADW{fill}}, imm};
    end else begin : g_nopad
      logic unused_zext;
      assign unused_zext = zext;
      assign ext = imm[XLEN-1:0];
    end
  endgenerate

endmodule

// File: rtl/rfi_exec.sv
module rfi_exec
  import rfi_alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  alu_kind_e       kind,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] y
);

  logic lt;
  assign lt = $signed(opa) < $signed(opb);

  always_comb begin
    unique case (kind)
      K_ADD:   y = opa + opb;
      K_SUB:   y = opa - opb;
      K_SLT:   y = {{(XLEN-1){1'b0}}, lt};
      K_OR:    y = opa | opb;
      K_LUI:   y = opb << IMMW;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/rfi_alu.sv
module rfi_alu
  import rfi_alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            out_valid,
  output logic            out_we,
  output logic [RIDX-1:0] out_dst,
  output logic [XLEN-1:0] out_data
);

  dec_t            dec;
  logic [RIDX-1:0] dst;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] alu_y;

  rfi_decode #(.XLEN(XLEN), .RIDX(RIDX)) u_dec (
    .instr (instr),
    .dec   (dec),
    .dst   (dst)
  );

  rfi_immext #(.XLEN(XLEN), .IMMW(IMM_W)) u_ext (
    .imm  (instr[IMM_W-1:0]),
    .zext (dec.zext),
    .ext  (imm_ext)
  );

  assign opnd_b = dec.use_imm ? imm_ext : src_b;

  rfi_exec #(.XLEN(XLEN), .IMMW(IMM_W)) u_exe (
    .kind (dec.kind),
    .opa  (src_a),
    .opb  (opnd_b),
    .y    (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
      out_dst   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_we    <= in_valid && dec.legal && (dst != '0);
      if (in_valid) begin
        out_dst  <= dec.legal ? dst   : '0;
        out_data <= dec.legal ? alu_y : '0;
      end
    end
  end

endmodule

// File: rtl/rfi_alu_chk.sv
module rfi_alu_chk
  import rfi_alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [XLEN-1:0] instr,
  input logic            out_valid,
  input logic            out_we,
  input logic [RIDX-1:0] out_dst,
  input logic [XLEN-1:0] out_data
);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_we && out_dst == '0 && out_data == '0));

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R11
  we_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_we |-> out_valid);

  // R8
  no_zero_dst_chk: assert property (@(posedge clk) disable iff (rst)
    out_we |-> (out_dst != '0));

  // R7
  lui_low_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(instr[OP_LSB +: OP_W]) == OPC_LUI)
      |-> (out_data[IMM_W-1:0] == '0));

  // R3
  slt_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(instr[OP_LSB +: OP_W]) == OPC_REG
      && $past(instr[FN_W-1:0]) == FN_SLT) |-> (out_data[XLEN-1:1] == '0));

endmodule

bind rfi_alu rfi_alu_chk #(.XLEN(XLEN), .RIDX(RIDX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .instr     (instr),
  .out_valid (out_valid),
  .out_we    (out_we),
  .out_dst   (out_dst),
  .out_data  (out_data)
);

// File: tb/rfi_alu_test.sv
module rfi_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        out_valid, out_we;
  logic [4:0]  out_dst;
  logic [31:0] out_data;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  rfi_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .out_we(out_we),
    .out_dst(out_dst), .out_data(out_data)
  );

  function automatic logic [31:0] mk_r(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction

  function automatic logic [31:0] mk_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  // expectation for the outputs after the coming clock edge
  logic        e_valid = 0, e_we = 0;
  logic [4:0]  e_dst = 0;
  logic [31:0] e_data = 0;
  string       e_tag = "R10";

  always @(posedge clk) begin
    int op, fn, imm;
    logic ok;
    logic [31:0] r;
    int d;
    if (rst) begin
      e_valid = 0; e_we = 0; e_dst = 0; e_data = 0; e_tag = "R10";
    end else if (!in_valid) begin
      e_valid = 0; e_we = 0; e_tag = "R11";
    end else begin
      op  = int'(instr[31:26]);
      fn  = int'(instr[5:0]);
      imm = int'(instr[15:0]);
      if (imm >= 32768) imm = imm - 65536;
      ok  = 1; r = 0;
      d   = (op == 0) ? int'(instr[15:11]) : int'(instr[20:16]);
      if (op == 0 && fn == 32) begin r = src_a + src_b; e_tag = "R1"; end
      else if (op == 0 && fn == 34) begin r = src_a - src_b; e_tag = "R2"; end
      else if (op == 0 && fn == 42) begin
        r = ($signed(src_a) < $signed(src_b)) ? 32'd1 : 32'd0; e_tag = "R3";
      end
      else if (op == 8) begin r = src_a + 32'(imm); e_tag = "R4"; end
      else if (op == 10) begin
        r = (longint'($signed(src_a)) < longint'(imm)) ? 32'd1 : 32'd0; e_tag = "R5";
      end
      else if (op == 13) begin r = src_a | 32'(int'(instr[15:0])); e_tag = "R6"; end
      else if (op == 15) begin r = 32'(int'(instr[15:0]) * 65536); e_tag = "R7"; end
      else begin ok = 0; e_tag = "R9"; end
      if (ok && d == 0) e_tag = "R8";
      e_valid = 1;
      e_we    = ok && (d != 0);
      e_dst   = ok ? 5'(d) : 5'd0;
      e_data  = ok ? r : 32'd0;
    end
  end

  always @(negedge clk) begin
    logic good;
    good = (out_valid === e_valid) && (out_we === e_we) &&
           (!e_valid || (out_dst === e_dst && out_data === e_data));
    compared++;
    if (!good) begin
      mismatched++;
      $display("FAIL %s: got v=%0b we=%0b dst=%0d data=%h, expected v=%0b we=%0b dst=%0d data=%h",
               e_tag, out_valid, out_we, out_dst, out_data, e_valid, e_we, e_dst, e_data);
    end
  end

  task automatic issue(input logic v, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    #1;
    in_valid = v; instr = ins; src_a = a; src_b = b;
  endtask

  function automatic logic [31:0] pick(int sel);
    int rs, rt, rd, im;
    rs = int'($urandom_range(31)); rt = int'($urandom_range(31));
    rd = int'($urandom_range(31)); im = int'($urandom_range(65535));
    case (sel)
      0: return mk_r(rs, rt, rd, 32);
      1: return mk_r(rs, rt, rd, 34);
      2: return mk_r(rs, rt, rd, 42);
      3: return mk_i(8, rs, rt, im);
      4: return mk_i(10, rs, rt, im);
      5: return mk_i(13, rs, rt, im);
      6: return mk_i(15, rs, rt, im);
      7: return mk_r(rs, rt, rd, int'($urandom_range(63)));
      default: return mk_i(int'($urandom_range(63)), rs, rt, im);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got no finish, expected finish before timeout");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] hi;
    repeat (4) @(negedge clk);   // R10 checked on each of these cycles
    #1 rst = 1'b0;
    // R1 add, including wrap-around
    issue(1, mk_r(1, 2, 3, 32), 32'd100, 32'd23);
    issue(1, mk_r(1, 2, 4, 32), 32'hFFFF_FFFF, 32'd2);
    // R2 subtract, including borrow
    issue(1, mk_r(1, 2, 5, 34), 32'd10, 32'd30);
    // R3 signed less-than: negative vs positive, equal, positive vs negative
    issue(1, mk_r(1, 2, 6, 42), 32'h8000_0000, 32'd1);
    issue(1, mk_r(1, 2, 6, 42), 32'd7, 32'd7);
    issue(1, mk_r(1, 2, 6, 42), 32'd1, 32'hFFFF_FFFF);
    // R4 add immediate with negative and positive constants
    issue(1, mk_i(8, 29, 29, 16'hFFFC), 32'h0000_1000, 32'hDEAD_BEEF);
    issue(1, mk_i(8, 29, 29, 4), 32'h0000_1000, 32'h0);
    // R5 set-less-than immediate against -1 and +15
    issue(1, mk_i(10, 18, 8, 16'hFFFF), 32'hFFFF_FFFE, 32'h0);
    issue(1, mk_i(10, 18, 8, 15), 32'd15, 32'h0);
    // R6 OR immediate: top bit of the field must not spread
    issue(1, mk_i(13, 8, 8, 16'h8001), 32'h0F00_0000, 32'h0);
    // R7 upper immediate: 6 gives 6*65536
    issue(1, mk_i(15, 0, 8, 6), 32'h1234_5678, 32'h9);
    // R8 destination 0 is not written
    issue(1, mk_r(1, 2, 0, 32), 32'd1, 32'd1);
    issue(1, mk_i(8, 1, 0, 5), 32'd1, 32'd0);
    // R9 unsupported opcode and function
    issue(1, mk_i(35, 1, 2, 100), 32'd1, 32'd2);
    issue(1, mk_r(1, 2, 3, 8), 32'd1, 32'd2);
    // R11 idle cycles produce nothing
    issue(0, mk_r(1, 2, 3, 32), 32'd1, 32'd2);
    issue(0, mk_i(15, 0, 3, 1), 32'd0, 32'd0);
    // R7 upper immediate then OR immediate builds a full constant
    issue(1, mk_i(15, 0, 9, 16'hABCD), 32'h0, 32'h0);
    @(negedge clk);
    hi = out_data;
    issue(1, mk_i(13, 9, 9, 16'h1234), hi, 32'h0);
    @(negedge clk);
    compared++;
    if (out_data !== 32'hABCD_1234 || out_we !== 1'b1 || out_dst !== 5'd9) begin
      mismatched++;
      $display("FAIL R7: got data=%h we=%0b dst=%0d, expected data=abcd1234 we=1 dst=9",
               out_data, out_we, out_dst);
    end
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      issue(($urandom_range(7) != 0), pick(int'($urandom_range(8))),
            $urandom(), ($urandom_range(3) == 0) ? 32'(int'($urandom_range(3))) : $urandom());
    end
    // R10 reset in mid-stream clears the outputs
    issue(1, mk_r(1, 2, 3, 32), 32'd5, 32'd6);
    @(negedge clk);
    #1 rst = 1'b1;
    repeat (2) @(negedge clk);
    #1 rst = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule